// File: doc/BRIEF.md
# External Memory Bus Sequencer for an 8-bit Controller Core

This block turns code-fetch and data-access requests from an 8-bit controller core into strobes and address/data sequencing on a multiplexed external bus. Time is divided into slots of six clock cycles, two slots per twelve-cycle machine cycle. Each slot is one of five kinds: idle, internal fetch, external fetch, data address, or data strobe. The block accepts at most one request per slot. A data access always takes two consecutive slots: an address slot followed by a strobe slot.

The low port carries the low address byte first and then data. The high port carries the upper address byte. For a register-indirect data access, the high port instead carries the port-latch byte supplied by the core. An enable input decides whether a fetch below a configurable boundary (default 2000H) is served from on-chip memory, in which case nothing moves on the bus. The byte read or fetched from the bus is returned to the core together with a valid pulse.

Top module: `xmb_bus_seq`

## Requirements
- R1: While reset is held, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `lo_oe` is 0 and `rsp_valid` is 0.
- R2: `req_take` is 1 in output cycle 4 of every slot except a data-address slot. The request is consumed on the clock edge that ends that cycle, and the new slot's cycle 0 comes two cycles later. `ale` is 1 in cycles 0 and 1 of every slot except a data-strobe slot.
- R3: An external fetch slot does the following. It drives `lo_out` = pc[7:0] with `lo_oe` = 1 in cycles 0 to 2. It drives `hi_out` = pc[15:8] for the whole slot. It holds `psen_n` low with `lo_oe` = 0 in cycles 3 to 5. In cycle 0 of the next slot, `rsp_valid` = 1, `rsp_internal` = 0 and `rsp_data` equals the `lo_in` value present at the end of cycle 5.
- R4: An internal fetch slot keeps `psen_n` high and `lo_oe` low for the whole slot. In cycle 0 of the next slot it gives `rsp_valid` = 1 with `rsp_internal` = 1 and `rsp_data` = 0.
- R5: A fetch is internal only when `int_code_en` = 1 and pc < INT_CODE_TOP (default 2000H). With the default, pc = 1FFFH is internal and pc = 2000H is external. With `int_code_en` = 0, every fetch is external.
- R6: A data-address slot pulses `ale` and keeps `psen_n` high. It drives the low address byte on `lo_out` with `lo_oe` = 1 for the whole slot. The low address byte is dptr[7:0] when `req_wide` = 1 and `ri_addr` otherwise. The high port shows dptr[15:8] when `req_wide` = 1 and `p2_latch` otherwise.
- R7: A data-strobe slot always follows a data-address slot. In it, `ale` stays 0 and `psen_n` stays 1, and `hi_out` keeps the value from the address slot.
- R8: A write strobe slot (`req_write` = 1) drives `wdata` on `lo_out` with `lo_oe` = 1 for the whole slot. It holds `wr_n` low in cycles 1 to 4 and keeps `rd_n` high.
- R9: A read strobe slot keeps `lo_oe` = 0 and holds `rd_n` low in cycles 1 to 4. In cycle 5 it gives `rsp_valid` = 1, `rsp_internal` = 0 and `rsp_data` equal to `lo_in` at the end of cycle 4.
- R10: A slot with no request still pulses `ale`. It keeps `psen_n`, `rd_n` and `wr_n` high, keeps `lo_oe` at 0, and gives no response.
- R11: In idle and internal-fetch slots, `hi_out` carries `p2_latch`.
- R12: `rd_n` and `wr_n` are never low together. Neither of them is low while `psen_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| int_code_en | input | 1 | 1 lets fetches below the boundary use on-chip memory |
| req_valid | input | 1 | A request is presented |
| req_fetch | input | 1 | 1 code fetch, 0 data access |
| req_write | input | 1 | Data access is a write |
| req_wide | input | 1 | Data access uses the 16-bit pointer |
| pc | input | 16 | Fetch address |
| dptr | input | 16 | 16-bit data pointer |
| ri_addr | input | 8 | 8-bit indirect data address |
| p2_latch | input | 8 | High-port latch byte |
| wdata | input | 8 | Write byte |
| req_take | output | 1 | Request consumed at the end of this cycle |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Fetched or read byte |
| rsp_internal | output | 1 | Fetch is to be served from on-chip memory |
| lo_in | input | 8 | Low port input from pads |
| lo_out | output | 8 | Low port address/data out |
| lo_oe | output | 1 | Low port strong drive enable |
| hi_out | output | 8 | High address port |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
Every bus output is registered. Slot cycle k therefore appears at the ports two cycles after the request edge plus k, and `req_take` falls in cycle 4 of the outgoing slot. The bench locks onto `req_take` at a falling clock edge and presents the request there. After that it samples every cycle of the slot at falling edges and compares the whole strobe, port and response vector with the value due in that cycle. It applies `lo_in` only across the single clock edge where capture is due: the end of cycle 5 for a fetch and the end of cycle 4 for a read. A response caught one cycle early or late therefore shows up as a wrong byte.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  typedef enum logic [2:0] {
    SK_IDLE  = 3'd0,
    SK_INTF  = 3'd1,
    SK_EXTF  = 3'd2,
    SK_DADDR = 3'd3,
    SK_DSTRB = 3'd4
  } slot_kind_e;
endpackage

// File: rtl/xmb_slot_timer.sv
module xmb_slot_timer #(
  parameter int SLOT_LEN = 6,
  localparam int PH_W = $clog2(SLOT_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph,
  output logic            slot_end
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_LEN - 1);

  assign slot_end = (ph == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst)           ph <= PH_LAST;
    else if (slot_end) ph <= '0;
    else               ph <= ph + 1'b1;
  end
endmodule

// File: rtl/xmb_req_latch.sv
module xmb_req_latch
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SLOT_LEN = 6,
  parameter logic [ADDR_W-1:0] INT_CODE_TOP = 16'h2000,
  localparam int PH_W = $clog2(SLOT_LEN),
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   ph,
  input  logic              slot_end,
  input  logic              int_code_en,
  input  logic              req_valid,
  input  logic              req_fetch,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [DATA_W-1:0] ri_addr,
  input  logic [HI_W-1:0]   p2_latch,
  input  logic [DATA_W-1:0] wdata,
  output slot_kind_e        kind,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              wr_q,
  output logic              req_take
);
  localparam logic [PH_W-1:0] PH_PRE = PH_W'(SLOT_LEN - 2);

  slot_kind_e  kind_nxt;
  logic        fetch_int;

  assign fetch_int = int_code_en && (pc < INT_CODE_TOP);

  always_comb begin
    if (kind == SK_DADDR)  kind_nxt = SK_DSTRB;
    else if (!req_valid)   kind_nxt = SK_IDLE;
    else if (!req_fetch)   kind_nxt = SK_DADDR;
    else if (fetch_int)    kind_nxt = SK_INTF;
    else                   kind_nxt = SK_EXTF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind     <= SK_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      wr_q     <= 1'b0;
      req_take <= 1'b1;
    end else begin
      req_take <= (ph == PH_PRE) && (kind != SK_DADDR);
      if (slot_end) begin
        kind <= kind_nxt;
        if (kind != SK_DADDR && req_valid) begin
          if (req_fetch) begin
            addr_q <= pc;
            wr_q   <= 1'b0;
          end else begin
            addr_q  <= req_wide ? dptr : {p2_latch, ri_addr};
            wr_q    <= req_write;
            wdata_q <= wdata;
          end
        end
      end
    end
  end
endmodule

// File: rtl/xmb_bus_drive.sv
module xmb_bus_drive
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SLOT_LEN = 6,
  parameter int ALE_CYC = 2,
  parameter int ADDR_CYC = 3,
  localparam int PH_W = $clog2(SLOT_LEN),
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   ph,
  input  slot_kind_e        kind,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              wr_q,
  input  logic [HI_W-1:0]   p2_latch,
  input  logic [DATA_W-1:0] lo_in,
  output logic [DATA_W-1:0] lo_out,
  output logic              lo_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_internal
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_LEN - 1);
  localparam logic [PH_W-1:0] PH_PRE  = PH_W'(SLOT_LEN - 2);
  localparam logic [PH_W-1:0] PH_ALE  = PH_W'(ALE_CYC);
  localparam logic [PH_W-1:0] PH_ADR  = PH_W'(ADDR_CYC);

  logic              ale_d, psen_d, strobe_d, oe_d, bus_hi;
  logic [DATA_W-1:0] lo_d;
  logic [HI_W-1:0]   hi_d;
  slot_kind_e        o_kind;
  logic [PH_W-1:0]   o_ph;
  logic              o_wr;

  always_comb begin
    ale_d    = (kind != SK_DSTRB) && (ph < PH_ALE);
    psen_d   = (kind == SK_EXTF) && (ph >= PH_ADR);
    strobe_d = (kind == SK_DSTRB) && (ph != '0) && (ph <= PH_PRE);
    unique case (kind)
      SK_EXTF:  oe_d = (ph < PH_ADR);
      SK_DADDR: oe_d = 1'b1;
      SK_DSTRB: oe_d = wr_q;
      default:  oe_d = 1'b0;
    endcase
    bus_hi = (kind == SK_EXTF) || (kind == SK_DADDR) || (kind == SK_DSTRB);
    hi_d   = bus_hi ? addr_q[ADDR_W-1:DATA_W] : p2_latch;
    if (!oe_d)                          lo_d = '0;
    else if (kind == SK_DSTRB)          lo_d = wdata_q;
    else                                lo_d = addr_q[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      lo_oe  <= 1'b0;
      lo_out <= '0;
      hi_out <= '0;
      o_kind <= SK_IDLE;
      o_ph   <= PH_LAST;
      o_wr   <= 1'b0;
    end else begin
      ale    <= ale_d;
      psen_n <= !psen_d;
      rd_n   <= !(strobe_d && !wr_q);
      wr_n   <= !(strobe_d && wr_q);
      lo_oe  <= oe_d;
      lo_out <= lo_d;
      hi_out <= hi_d;
      o_kind <= kind;
      o_ph   <= ph;
      o_wr   <= wr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_internal <= 1'b0;
    end else if (o_kind == SK_EXTF && o_ph == PH_LAST) begin
      rsp_valid    <= 1'b1;
      rsp_data     <= lo_in;
      rsp_internal <= 1'b0;
    end else if (o_kind == SK_DSTRB && !o_wr && o_ph == PH_PRE) begin
      rsp_valid    <= 1'b1;
      rsp_data     <= lo_in;
      rsp_internal <= 1'b0;
    end else if (o_kind == SK_INTF && o_ph == PH_LAST) begin
      rsp_valid    <= 1'b1;
      rsp_data     <= '0;
      rsp_internal <= 1'b1;
    end else begin
      rsp_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/xmb_bus_seq.sv
module xmb_bus_seq
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SLOT_LEN = 6,
  parameter int ALE_CYC = 2,
  parameter int ADDR_CYC = 3,
  parameter logic [ADDR_W-1:0] INT_CODE_TOP = 16'h2000,
  localparam int PH_W = $clog2(SLOT_LEN),
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_code_en,
  input  logic              req_valid,
  input  logic              req_fetch,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [DATA_W-1:0] ri_addr,
  input  logic [HI_W-1:0]   p2_latch,
  input  logic [DATA_W-1:0] wdata,
  output logic              req_take,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_internal,
  input  logic [DATA_W-1:0] lo_in,
  output logic [DATA_W-1:0] lo_out,
  output logic              lo_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);
  logic [PH_W-1:0]   ph;
  logic              slot_end;
  slot_kind_e        kind;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;

  xmb_slot_timer #(.SLOT_LEN(SLOT_LEN)) timer_i (
    .clk(clk), .rst(rst), .ph(ph), .slot_end(slot_end)
  );

  xmb_req_latch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_LEN(SLOT_LEN), .INT_CODE_TOP(INT_CODE_TOP)
  ) req_i (
    .clk(clk), .rst(rst), .ph(ph), .slot_end(slot_end),
    .int_code_en(int_code_en), .req_valid(req_valid), .req_fetch(req_fetch),
    .req_write(req_write), .req_wide(req_wide), .pc(pc), .dptr(dptr),
    .ri_addr(ri_addr), .p2_latch(p2_latch), .wdata(wdata),
    .kind(kind), .addr_q(addr_q), .wdata_q(wdata_q), .wr_q(wr_q), .req_take(req_take)
  );

  xmb_bus_drive #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_LEN(SLOT_LEN),
    .ALE_CYC(ALE_CYC), .ADDR_CYC(ADDR_CYC)
  ) drv_i (
    .clk(clk), .rst(rst), .ph(ph), .kind(kind), .addr_q(addr_q),
    .wdata_q(wdata_q), .wr_q(wr_q), .p2_latch(p2_latch), .lo_in(lo_in),
    .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_internal(rsp_internal)
  );
endmodule

// File: rtl/xmb_bus_seq_chk.sv
module xmb_bus_seq_chk (
  input logic clk,
  input logic rst,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic lo_oe
);
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R12
  AST_PSEN_NOT_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> (rd_n && wr_n)); // R12
  AST_ALE_TWO_WIDE: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale); // R2
  AST_ALE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (ale && $past(ale)) |=> !ale); // R2
  AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> (!ale && psen_n)); // R7
  AST_PSEN_RELEASES: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> !lo_oe); // R3
  AST_PSEN_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n) |-> $past(ale, 2)); // R3
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> lo_oe); // R8
  AST_RD_FLOATS: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !lo_oe); // R9
endmodule

bind xmb_bus_seq xmb_bus_seq_chk chk_i (
  .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n),
  .rd_n(rd_n), .wr_n(wr_n), .lo_oe(lo_oe)
);

// File: tb/xmb_bus_seq_tb.sv
module xmb_bus_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        int_code_en = 1'b1;
  logic        req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [15:0] pc = '0, dptr = '0;
  logic [7:0]  ri_addr = '0, p2_latch = 8'h7C, wdata = '0, lo_in = '0;
  logic        req_take, rsp_valid, rsp_internal, lo_oe, ale, psen_n, rd_n, wr_n;
  logic [7:0]  rsp_data, lo_out, hi_out;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  xmb_bus_seq dut_i (
    .clk(clk), .rst(rst), .int_code_en(int_code_en), .req_valid(req_valid),
    .req_fetch(req_fetch), .req_write(req_write), .req_wide(req_wide),
    .pc(pc), .dptr(dptr), .ri_addr(ri_addr), .p2_latch(p2_latch), .wdata(wdata),
    .req_take(req_take), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_internal(rsp_internal), .lo_in(lo_in), .lo_out(lo_out), .lo_oe(lo_oe),
    .hi_out(hi_out), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // slot types: 0 idle, 1 internal fetch, 2 external fetch, 3 data address, 4 read strobe, 5 write strobe
  function automatic logic [4:0] exp_ctl(input int t, input int k);
    logic a, p, r, w, o;
    a = (t != 4 && t != 5) && k < 2;
    p = !(t == 2 && k >= 3);
    r = !(t == 4 && k >= 1 && k <= 4);
    w = !(t == 5 && k >= 1 && k <= 4);
    o = (t == 2 && k < 3) || t == 3 || t == 5;
    return {a, p, r, w, o};
  endfunction

  // Present one request and check every cycle of the slot(s) it causes.
  task automatic play(input string req, input int t, input bit wr,
                      input logic [7:0] exp_lo, input logic [7:0] exp_hi,
                      input logic [7:0] exp_wd, input logic [7:0] byte_in);
    int nsl;
    while (1) begin
      @(negedge clk);
      if (req_take) break;
    end
    req_valid = (t != 0);
    @(negedge clk);
    req_valid = 1'b0;
    nsl = (t == 3) ? 2 : 1;
    for (int s = 0; s < nsl; s++) begin
      for (int k = 0; k < 6; k++) begin
        int tt;
        int cap;
        logic [4:0] ec;
        logic [7:0] elo;
        logic       erv;
        @(negedge clk);
        tt  = (s == 0) ? t : (wr ? 5 : 4);
        ec  = exp_ctl(tt, k);
        elo = ec[0] ? ((tt == 5) ? exp_wd : exp_lo) : 8'h00;
        erv = (tt == 4 && k == 5);
        check({req, " bus vector"},
              {10'd0, ale, psen_n, rd_n, wr_n, lo_oe, rsp_valid, (lo_oe ? lo_out : 8'h00), hi_out},
              {10'd0, ec, erv, elo, exp_hi});
        check("R2 req_take", {31'd0, req_take}, {31'd0, (k == 4 && tt != 3)});
        if (erv) check("R9 read byte", {23'd0, rsp_internal, rsp_data}, {23'd0, 1'b0, byte_in});
        cap = (tt == 2) ? 5 : (tt == 4) ? 4 : -1;
        lo_in = (k == cap) ? byte_in : ~byte_in;
      end
    end
    @(negedge clk);
    if (t == 1 || t == 2)
      check({req, " fetch response"}, {22'd0, rsp_valid, rsp_internal, rsp_data},
            {22'd0, 1'b1, (t == 1), (t == 1) ? 8'h00 : byte_in});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state", {26'd0, ale, psen_n, rd_n, wr_n, lo_oe, rsp_valid},
          {26'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
    rst = 1'b0;
  endtask

  task automatic t_idle;       // R10 R11
    play("R10 idle slot", 0, 0, 8'h00, p2_latch, 8'h00, 8'h00);
  endtask

  task automatic t_ext_fetch_disabled;   // R3 R5
    int_code_en = 1'b0; req_fetch = 1'b1; pc = 16'h0123;
    play("R3 external fetch", 2, 0, 8'h23, 8'h01, 8'h00, 8'hE7);
  endtask

  task automatic t_int_fetch_edge;       // R4 R5 R11
    int_code_en = 1'b1; req_fetch = 1'b1; pc = 16'h1FFF;
    play("R5 internal fetch below boundary", 1, 0, 8'h00, p2_latch, 8'h00, 8'h00);
  endtask

  task automatic t_ext_fetch_boundary;   // R5
    int_code_en = 1'b1; req_fetch = 1'b1; pc = 16'h2000;
    play("R5 external fetch at boundary", 2, 0, 8'h00, 8'h20, 8'h00, 8'h96);
  endtask

  task automatic t_write_wide;           // R6 R7 R8 R12
    req_fetch = 1'b0; req_write = 1'b1; req_wide = 1'b1; dptr = 16'hBEEF; wdata = 8'h5A;
    play("R8 wide write", 3, 1, 8'hEF, 8'hBE, 8'h5A, 8'h00);
  endtask

  task automatic t_read_narrow;          // R6 R7 R9
    req_fetch = 1'b0; req_write = 1'b0; req_wide = 1'b0; ri_addr = 8'h33;
    play("R6 narrow read", 3, 0, 8'h33, p2_latch, 8'h00, 8'hC3);
  endtask

  task automatic t_read_wide;            // R6 R9
    req_fetch = 1'b0; req_write = 1'b0; req_wide = 1'b1; dptr = 16'h4181;
    play("R9 wide read", 3, 0, 8'h81, 8'h41, 8'h00, 8'h3C);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_ext_fetch_disabled();
    t_int_fetch_edge();
    t_ext_fetch_boundary();
    t_write_wide();
    t_read_narrow();
    t_read_wide();
    t_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule